// File: doc/BRIEF.md
# Endpoint-Zero Mode/Count Status Register with Write Interlock

This block holds the status and control state of USB endpoint zero. Two agents share it: a serial interface engine (SIE) that handles the host's transactions, and a CPU on a register bus. The mode register has four event flags in its upper nibble and the endpoint response mode in its lower bits. A companion count register is locked and released under the same rules. Any update from the SIE locks both registers. From then on the CPU cannot overwrite what the SIE has just posted until the CPU has read the mode register.

The SIE reports events as one-cycle strobes:
- a valid SETUP,
- IN data acknowledged by the host,
- the last OUT packet received and acknowledged,
- any transaction that completes with an ACK.

The SIE can also load the mode and count fields directly. A separate input marks the data phase of a control-write transfer. While that input is high, the SETUP flag is forced to 1. While the SETUP flag is set, the block asserts an inhibit output that keeps the CPU from writing the endpoint FIFO. What each mode value means for USB traffic is handled elsewhere, and so is the FIFO storage.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset, `mode_q` and `cnt_q` are all zero, `locked` is 0 and `fifo_wr_inhibit` is 0.
- R2: Flag positions in `mode_q` are: bit 7 = SETUP, bit 6 = IN acknowledged, bit 5 = OUT acknowledged, bit 4 = ACKed transaction, bits 3:0 = mode. A one-cycle strobe on an event input sets its flag on the next clock edge. The flag then stays set until it is cleared.
- R3: Any SIE update locks both registers, and `locked` reads 1 after the next edge. An SIE update is any of: `sie_wr_mode`, `sie_wr_cnt`, or any of the four event strobes.
- R4: While `locked` is 1, CPU writes to the mode register and to the count register have no effect.
- R5: A CPU read of the mode register (`cpu_rd_mode`) releases the lock on the next edge, but only if no SIE update occurs in the same cycle. A read in the same cycle as an SIE update leaves the lock set.
- R6: An accepted CPU mode write (unlocked, no SIE update that cycle) sets bits 3:0 to `cpu_wdata[3:0]` and clears flag bits 7:4, whatever `cpu_wdata[7:4]` holds.
- R7: The CPU can never set a flag. Writing 1s to `cpu_wdata[7:4]` leaves those flags at 0.
- R8: While `ctl_wr_data_phase` is 1, the SETUP flag is 1 on the next edge. An accepted CPU mode write in that window leaves SETUP at 1 and clears the other three flags.
- R9: `fifo_wr_inhibit` is 1 exactly when the SETUP flag (bit 7 of `mode_q`) is 1.
- R10: An SIE update has priority over a CPU write in the same cycle. The CPU write is dropped even if the register was unlocked.
- R11: `sie_wr_cnt` loads `sie_cnt` into `cnt_q`. An accepted CPU count write loads `cpu_wdata[CNT_W-1:0]` into `cnt_q` and leaves `mode_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_mode | input | 1 | CPU write strobe for the mode register |
| cpu_wr_cnt | input | 1 | CPU write strobe for the count register |
| cpu_rd_mode | input | 1 | CPU read strobe for the mode register (releases the lock) |
| cpu_wdata | input | 4+MODE_W | CPU write data |
| sie_wr_mode | input | 1 | SIE load of the mode field |
| sie_mode | input | MODE_W | Mode value from the SIE |
| sie_wr_cnt | input | 1 | SIE load of the count register |
| sie_cnt | input | CNT_W | Count value from the SIE |
| sie_setup_ev | input | 1 | Strobe: valid SETUP received |
| sie_in_ack_ev | input | 1 | Strobe: host acknowledged IN data |
| sie_out_ack_ev | input | 1 | Strobe: last OUT packet received and ACKed |
| sie_ack_ev | input | 1 | Strobe: a transaction completed with an ACK |
| ctl_wr_data_phase | input | 1 | High during the data phase of a control write |
| mode_q | output | 4+MODE_W | Flags and mode |
| cnt_q | output | CNT_W | Count register |
| locked | output | 1 | Interlock state |
| fifo_wr_inhibit | output | 1 | Blocks CPU writes to the endpoint FIFO |

## Verification
The assertions assume that every event input and every write or read strobe is a synchronous level, sampled once per clock. They also assume that `ctl_wr_data_phase` has already been raised by the time a CPU write is expected to spare the SETUP flag. The bench changes every input one time unit after a rising edge and holds each strobe for exactly one cycle. It raises the data-phase input before the SETUP strobe and lowers it only between CPU accesses. This means no write ever meets a half-changed phase.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;
   localparam int FLAG_N = 4;
   // flag index within the flag nibble (nibble bit 3 maps to register bit 7)
   localparam int FL_ACK   = 0;
   localparam int FL_OUT   = 1;
   localparam int FL_IN    = 2;
   localparam int FL_SETUP = 3;

   typedef struct packed {
      logic setup;
      logic in_ack;
      logic out_ack;
      logic ack;
   } ep0_ev_t;
endpackage

// File: rtl/ep0_lock_ctl.sv
module ep0_lock_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sie_any,
   input  logic cpu_rd,
   output logic lock_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (sie_any)
         lock_q <= 1'b1;
      else if (cpu_rd)
         lock_q <= 1'b0;
   end
endmodule

// File: rtl/ep0_flag_bit.sv
module ep0_flag_bit #(
   parameter bit HOLDABLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr,
   input  logic hold,
   output logic q
);
   logic force_hi;

   generate
      if (HOLDABLE) begin : g_hold
         assign force_hi = hold;
      end else begin : g_nohold
         logic unused_hold;
         assign unused_hold = hold;
         assign force_hi = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= force_hi | set_ev | (q & ~clr);
   end
endmodule

// File: rtl/ep0_field_reg.sv
module ep0_field_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sie_ld,
   input  logic [W-1:0] sie_val,
   input  logic         cpu_ld,
   input  logic [W-1:0] cpu_val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (sie_ld)
         q <= sie_val;
      else if (cpu_ld)
         q <= cpu_val;
   end
endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
   import ep0_stat_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter int CNT_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cpu_wr_mode,
   input  logic                     cpu_wr_cnt,
   input  logic                     cpu_rd_mode,
   input  logic [FLAG_N+MODE_W-1:0] cpu_wdata,
   input  logic                     sie_wr_mode,
   input  logic [MODE_W-1:0]        sie_mode,
   input  logic                     sie_wr_cnt,
   input  logic [CNT_W-1:0]         sie_cnt,
   input  logic                     sie_setup_ev,
   input  logic                     sie_in_ack_ev,
   input  logic                     sie_out_ack_ev,
   input  logic                     sie_ack_ev,
   input  logic                     ctl_wr_data_phase,
   output logic [FLAG_N+MODE_W-1:0] mode_q,
   output logic [CNT_W-1:0]         cnt_q,
   output logic                     locked,
   output logic                     fifo_wr_inhibit
);
   localparam int REG_W = FLAG_N + MODE_W;

   generate
      if (MODE_W < 1) begin : g_bad_mode
         $error("MODE_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and the register width");
      end
   endgenerate

   ep0_ev_t           ev;
   logic [FLAG_N-1:0] ev_vec;
   logic [FLAG_N-1:0] flags;
   logic              sie_any;
   logic              cpu_ok;
   logic              cpu_mode_ok;
   logic              cpu_cnt_ok;
   logic [MODE_W-1:0] mode_f;

   assign ev      = '{setup: sie_setup_ev, in_ack: sie_in_ack_ev,
                      out_ack: sie_out_ack_ev, ack: sie_ack_ev};
   assign ev_vec  = ev;
   assign sie_any = sie_wr_mode | sie_wr_cnt | (|ev_vec);
   // SIE activity wins; the interlock gates everything else
   assign cpu_ok      = ~locked & ~sie_any;
   assign cpu_mode_ok = cpu_ok & cpu_wr_mode;
   assign cpu_cnt_ok  = cpu_ok & cpu_wr_cnt;

   ep0_lock_ctl u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .sie_any(sie_any),
      .cpu_rd (cpu_rd_mode),
      .lock_q (locked)
   );

   genvar gi;
   generate
      for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
         ep0_flag_bit #(.HOLDABLE(gi == FL_SETUP)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_ev(ev_vec[gi]),
            .clr   (cpu_mode_ok),
            .hold  (ctl_wr_data_phase),
            .q     (flags[gi])
         );
      end
   endgenerate

   ep0_field_reg #(.W(MODE_W)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .sie_ld (sie_wr_mode),
      .sie_val(sie_mode),
      .cpu_ld (cpu_mode_ok),
      .cpu_val(cpu_wdata[MODE_W-1:0]),
      .q      (mode_f)
   );

   ep0_field_reg #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sie_ld (sie_wr_cnt),
      .sie_val(sie_cnt),
      .cpu_ld (cpu_cnt_ok),
      .cpu_val(cpu_wdata[CNT_W-1:0]),
      .q      (cnt_q)
   );

   assign mode_q          = {flags, mode_f};
   assign fifo_wr_inhibit = flags[FL_SETUP];
endmodule

// File: rtl/ep0_ctl_status_chk.sv
module ep0_ctl_status_chk #(
   parameter int MODE_W = 4,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr_mode,
   input logic              cpu_rd_mode,
   input logic              sie_wr_mode,
   input logic              sie_wr_cnt,
   input logic              sie_setup_ev,
   input logic              sie_in_ack_ev,
   input logic              sie_out_ack_ev,
   input logic              sie_ack_ev,
   input logic              ctl_wr_data_phase,
   input logic [MODE_W+3:0] mode_q,
   input logic              locked
);
   localparam int TOP = MODE_W + 3;
   logic sie_act;
   assign sie_act = sie_wr_mode | sie_wr_cnt | sie_setup_ev | sie_in_ack_ev
                    | sie_out_ack_ev | sie_ack_ev;

   // R3
   sie_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sie_act |=> locked);

   // R4
   locked_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cpu_wr_mode && !sie_act && !ctl_wr_data_phase)
      |=> (mode_q == $past(mode_q)));

   // R5
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cpu_rd_mode && !sie_act) |=> !locked);

   // R6
   wr_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && cpu_wr_mode && !sie_act && !ctl_wr_data_phase)
      |=> (mode_q[TOP -: 4] == 4'b0000));

   // R8
   setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_data_phase |=> mode_q[TOP]);

   // R2
   in_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_q[TOP-1]) |-> $past(sie_in_ack_ev));
endmodule

bind ep0_ctl_status ep0_ctl_status_chk #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cpu_wr_mode      (cpu_wr_mode),
   .cpu_rd_mode      (cpu_rd_mode),
   .sie_wr_mode      (sie_wr_mode),
   .sie_wr_cnt       (sie_wr_cnt),
   .sie_setup_ev     (sie_setup_ev),
   .sie_in_ack_ev    (sie_in_ack_ev),
   .sie_out_ack_ev   (sie_out_ack_ev),
   .sie_ack_ev       (sie_ack_ev),
   .ctl_wr_data_phase(ctl_wr_data_phase),
   .mode_q           (mode_q),
   .locked           (locked)
);

// File: tb/test_ep0_ctl_status.sv
`timescale 1ns/1ps
module test_ep0_ctl_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr_mode = 0, cpu_wr_cnt = 0, cpu_rd_mode = 0;
   logic [7:0] cpu_wdata = '0;
   logic       sie_wr_mode = 0, sie_wr_cnt = 0;
   logic [3:0] sie_mode = '0, sie_cnt = '0;
   logic       sie_setup_ev = 0, sie_in_ack_ev = 0, sie_out_ack_ev = 0, sie_ack_ev = 0;
   logic       ctl_wr_data_phase = 0;
   logic [7:0] mode_q;
   logic [3:0] cnt_q;
   logic       locked, fifo_wr_inhibit;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   ep0_ctl_status i_ep0_ctl_status (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_wr_mode = 0; cpu_wr_cnt = 0; cpu_rd_mode = 0; cpu_wdata = '0;
      sie_wr_mode = 0; sie_wr_cnt = 0;
      sie_setup_ev = 0; sie_in_ack_ev = 0; sie_out_ack_ev = 0; sie_ack_ev = 0;
   endtask

   task automatic step();
      @(posedge clk); #1;
      idle();
   endtask

   task automatic cpu_read();
      cpu_rd_mode = 1; step();
   endtask

   task automatic cpu_write(input logic [7:0] d);
      cpu_wr_mode = 1; cpu_wdata = d; step();
   endtask

   task automatic t_reset();
      check("R1 mode", mode_q, 8'h00);
      check("R1 cnt", cnt_q, 4'h0);
      check("R1 lock", locked, 1'b0);
      check("R1 inhibit", fifo_wr_inhibit, 1'b0);
   endtask

   task automatic t_flags();
      sie_setup_ev = 1; step();
      check("R2 setup bit7", mode_q, 8'h80);
      check("R3 lock after event", locked, 1'b1);
      check("R9 inhibit set", fifo_wr_inhibit, 1'b1);
      cpu_read();
      check("R5 read releases", locked, 1'b0);
      cpu_write(8'h03);
      check("R6 write clears setup", mode_q, 8'h03);
      check("R9 inhibit clear", fifo_wr_inhibit, 1'b0);
      sie_in_ack_ev = 1; step();
      check("R2 in bit6", mode_q, 8'h43);
      sie_out_ack_ev = 1; step();
      check("R2 out bit5", mode_q, 8'h63);
      sie_ack_ev = 1; step();
      check("R2 ack bit4", mode_q, 8'h73);
   endtask

   task automatic t_lock();
      cpu_write(8'h05);
      check("R4 locked mode write ignored", mode_q, 8'h73);
      cpu_wr_cnt = 1; cpu_wdata = 8'h09; step();
      check("R4 locked cnt write ignored", cnt_q, 4'h0);
      cpu_read();
      cpu_write(8'hF5);
      check("R7 cpu cannot set flags", mode_q, 8'h05);
   endtask

   task automatic t_same_cycle_read();
      sie_wr_mode = 1; sie_mode = 4'hA; cpu_rd_mode = 1; step();
      check("R5 sie mode load", mode_q, 8'h0A);
      check("R5 read with sie update keeps lock", locked, 1'b1);
      cpu_write(8'h01);
      check("R5 still locked, write ignored", mode_q, 8'h0A);
      cpu_read();
      check("R5 later read releases", locked, 1'b0);
   endtask

   task automatic t_setup_hold();
      ctl_wr_data_phase = 1; sie_setup_ev = 1; step();
      check("R8 setup during phase", mode_q, 8'h8A);
      cpu_read();
      sie_ack_ev = 1; step();
      check("R8 ack during phase", mode_q, 8'h9A);
      cpu_read();
      cpu_write(8'h02);
      check("R8 setup held across write", mode_q, 8'h82);
      check("R9 inhibit held", fifo_wr_inhibit, 1'b1);
      ctl_wr_data_phase = 0;
      cpu_write(8'h02);
      check("R8 setup clears after phase", mode_q, 8'h02);
      check("R9 inhibit drops", fifo_wr_inhibit, 1'b0);
   endtask

   task automatic t_collision();
      check("R10 unlocked before", locked, 1'b0);
      cpu_wr_mode = 1; cpu_wdata = 8'h07; sie_out_ack_ev = 1; step();
      check("R10 sie wins, cpu dropped", mode_q, 8'h22);
      check("R10 locked", locked, 1'b1);
      cpu_read();
      cpu_write(8'h07);
      check("R10 later write accepted", mode_q, 8'h07);
   endtask

   task automatic t_count();
      sie_wr_cnt = 1; sie_cnt = 4'h5; step();
      check("R11 sie cnt load", cnt_q, 4'h5);
      check("R3 cnt write locks", locked, 1'b1);
      check("R11 mode untouched", mode_q, 8'h07);
      cpu_read();
      cpu_wr_cnt = 1; cpu_wdata = 8'h3C; step();
      check("R11 cpu cnt load", cnt_q, 4'hC);
      check("R11 mode unchanged by cnt write", mode_q, 8'h07);
   endtask

   initial begin : watchdog
      #2000000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_flags();
      t_lock();
      t_same_cycle_read();
      t_setup_hold();
      t_collision();
      t_count();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule